// File: doc/BRIEF.md
# Disk Controller Data FIFO

This block is the byte buffer between the host or DMA side and the disk serializer side of a floppy-style disk controller. It holds up to sixteen bytes. A direction input selects the path. When the transfer goes to the host, the disk side writes and the host reads. When it goes to the disk, the host writes and the disk side reads. After reset the buffer is limited to a single byte, so it acts as a plain holding register. A configuration input turns on the full depth, but only while a data transfer command is executing. During the command phase the single-byte behaviour always applies.

In the full-depth mode a programmable threshold controls the service request to the DMA engine. When reading, the request rises once enough bytes are waiting and stays up until the buffer is empty. When writing, the request rises once enough free slots exist and stays up until the buffer is full. The buffer empties itself on entry to the execution phase and again at the start of each command.

The block also handles transfer errors. A disk-side byte that arrives while the buffer is full is lost and recorded as an overrun. A disk-side byte request while the buffer is empty is recorded as an underrun. After an underrun, zero bytes are fed to the serializer up to the sector end, and then a one-cycle pulse asks for the CRC to be appended.

Top module: `disk_data_fifo`

## Requirements
- R1: After reset the overrun, underrun, error and crc_append outputs are low, drq is low, and the enable input for full depth reads as disabled until it is driven.
- R2: While a command executes with full depth disabled, the buffer accepts exactly one byte; rqm falls after that byte is written in the to-disk direction.
- R3: While exec_active is low (command phase), the buffer holds at most one byte, even when the full-depth enable is set.
- R4: The buffer is emptied on the first cycle that exec_active is high after being low, and on any cmd_start pulse. Bytes written before that point are never delivered.
- R5: In the to-host direction (dir_to_host=1) with full depth, drq asserts when the stored count is at least cfg_thresh (a value of 0 counts as 1). It then stays asserted until the count reaches zero.
- R6: Bytes leave in the order they entered, and up to 16 bytes can be stored at once.
- R7: In the to-disk direction (dir_to_host=0), drq asserts when the free slots are at least the threshold. It then stays asserted until no slot is free.
- R8: drq is asserted only while cfg_dma_en and exec_active are both high.
- R9: In the to-host direction during execution, a disk write while the buffer is full drops that byte. overrun and xfer_err go high after that clock edge and stay high. The bytes already stored can still be read out in order.
- R10: A cmd_start pulse clears overrun and underrun at the next edge.
- R11: In the to-disk direction during execution, a disk read with the buffer empty returns 0x00 and sets underrun. After that, host writes are ignored, rqm stays low and every disk-side byte is 0x00.
- R12: After an underrun, crc_append is a single-cycle pulse. It is high in the cycle after the disk read that takes byte number sector_len of the sector. The sector byte count restarts at cmd_start and at execution entry.
- R13: dio equals dir_to_host. rqm is high in the to-host direction when a byte is stored. In the to-disk direction it is high when a slot is free and no underrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fifo_en | input | 1 | Allows full depth during execution |
| cfg_thresh | input | 4 | Service threshold in bytes (0 counts as 1) |
| cfg_dma_en | input | 1 | DMA service requests allowed |
| cmd_start | input | 1 | Pulse at the start of a command |
| exec_active | input | 1 | High while a data transfer executes |
| dir_to_host | input | 1 | 1: disk to host, 0: host to disk |
| sector_len | input | 16 | Bytes per sector |
| host_wr | input | 1 | Host byte write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host byte read strobe |
| host_rdata | output | 8 | Byte presented to the host |
| dsk_wr | input | 1 | Disk-side byte write strobe |
| dsk_wdata | input | 8 | Disk-side write byte |
| dsk_rd | input | 1 | Disk-side byte request |
| dsk_rdata | output | 8 | Byte presented to the serializer |
| rqm | output | 1 | Host may transfer a byte |
| dio | output | 1 | Transfer direction status |
| drq | output | 1 | DMA service request |
| overrun | output | 1 | Sticky overrun flag |
| underrun | output | 1 | Sticky underrun flag |
| xfer_err | output | 1 | Overrun or underrun present |
| crc_append | output | 1 | One-cycle request to append CRC |

## Verification
The bench checks the edges of the drq hysteresis. It samples just below and at the threshold, then again with one byte left and with none left. A design that compares with the wrong inequality, or that drops the request as soon as the count falls below the threshold, fails at one of these points. It also checks the 16-byte fill followed by a dropped extra byte, with the order of the drained bytes compared against a scoreboard. A design that overwrites the oldest byte shows a wrong sequence there. The underrun case checks for a zero byte, for the ignored host write and for the exact cycle of the CRC pulse. An off-by-one in the sector count moves the pulse by a cycle. Stale bytes written before execution entry must not appear afterwards, which exposes a missing flush.

// File: rtl/disk_fifo_pkg.sv
// Package: shared types and sizing for the disk data FIFO.
// Assumes: all modules of the block import it.
package disk_fifo_pkg;
    typedef enum logic {
        XFER_TO_DISK = 1'b0,
        XFER_TO_HOST = 1'b1
    } xfer_dir_e;

    localparam int unsigned DEF_DEPTH  = 16;
    localparam int unsigned DEF_WIDTH  = 8;
    localparam int unsigned DEF_LEN_W  = 16;
endpackage

// File: rtl/disk_fifo_store.sv
// Module: circular byte store with a run-time capacity limit.
// It takes a push and a pop per cycle and refuses pushes at the
// capacity limit. It refuses pops when empty and ignores both during a flush.
// Assumes: cap never exceeds DEPTH. head reads as zero when empty.
module disk_fifo_store #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    input  logic [CW-1:0] cap,
    output logic [W-1:0]  head,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          push_ok;
    logic          pop_ok;

    // Status and accepted strobes from the current occupancy.
    always_comb begin
        full    = (level >= cap);
        empty   = (level == '0);
        push_ok = push & ~full & ~flush;
        pop_ok  = pop & ~empty & ~flush;
        head    = empty ? '0 : mem[rd_ptr];
    end

    // Storage array write.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy update with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/disk_fifo_req.sv
// Module: threshold service request with hysteresis.
// When reading it sets on count >= threshold and clears at empty.
// When writing it sets on free slots >= threshold and clears at full.
// Assumes: level and cap come from the store. A threshold of zero counts as one.
module disk_fifo_req #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned TW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          to_host,
    input  logic          en,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] cap,
    input  logic [TW-1:0] thr,
    output logic          drq
);
    logic [CW-1:0] thr_eff;
    logic [CW-1:0] free_slots;
    logic          set_c;
    logic          clr_c;
    logic          req_q;

    // Set and clear conditions for the current direction.
    always_comb begin
        thr_eff    = (thr == '0) ? CW'(1) : CW'(thr);
        free_slots = (level >= cap) ? '0 : cap - level;
        set_c      = to_host ? (level >= thr_eff) : (free_slots >= thr_eff);
        clr_c      = to_host ? (level == '0) : (free_slots == '0);
        drq        = en & (set_c | (req_q & ~clr_c));
    end

    // Remember the request between the two thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= drq;
    end
endmodule

// File: rtl/disk_fifo_pad.sv
// Module: sector byte counter, underrun flag and zero padding control.
// It counts disk-side byte requests in the to-disk direction. An empty
// request flags underrun and starts padding. At the sector end it emits a
// one-cycle CRC request.
// Assumes: restart is the command start pulse, sec_clr also covers execution entry.
module disk_fifo_pad #(
    parameter int unsigned LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          sec_clr,
    input  logic          active,
    input  logic          take,
    input  logic          empty,
    input  logic [LW-1:0] sec_len,
    output logic          underrun,
    output logic          crc_pulse
);
    logic [LW-1:0] sec_cnt;
    logic          padding;
    logic          last_c;
    logic          unr_evt;

    // Sector end and underrun event detection.
    always_comb begin
        last_c  = ({1'b0, sec_cnt} + 1'b1) >= {1'b0, sec_len};
        unr_evt = active & take & empty & ~underrun;
    end

    // Sector counting, sticky underrun, padding and CRC pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_cnt   <= '0;
            padding   <= 1'b0;
            underrun  <= 1'b0;
            crc_pulse <= 1'b0;
        end else begin
            crc_pulse <= 1'b0;
            if (restart) begin
                sec_cnt  <= '0;
                padding  <= 1'b0;
                underrun <= 1'b0;
            end else begin
                if (sec_clr) begin
                    sec_cnt <= '0;
                end else if (active && take) begin
                    if (last_c) begin
                        sec_cnt <= '0;
                        if (padding || unr_evt) begin
                            crc_pulse <= 1'b1;
                            padding   <= 1'b0;
                        end
                    end else begin
                        sec_cnt <= sec_cnt + 1'b1;
                        if (unr_evt) padding <= 1'b1;
                    end
                end
                if (unr_evt) underrun <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/disk_data_fifo.sv
// Module: top of the disk controller data FIFO.
// It steers host and disk strobes by direction. It limits depth to one byte
// outside full-depth execution, flushes on execution entry and command start,
// and flags overrun. Underrun and padding come from disk_fifo_pad.
// Assumes: strobes are single-cycle per byte and synchronous to clk.
module disk_data_fifo
    import disk_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned W     = DEF_WIDTH,
    parameter int unsigned LW    = DEF_LEN_W,
    localparam int unsigned TW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_fifo_en,
    input  logic [TW-1:0] cfg_thresh,
    input  logic          cfg_dma_en,
    input  logic          cmd_start,
    input  logic          exec_active,
    input  logic          dir_to_host,
    input  logic [LW-1:0] sector_len,
    input  logic          host_wr,
    input  logic [W-1:0]  host_wdata,
    input  logic          host_rd,
    output logic [W-1:0]  host_rdata,
    input  logic          dsk_wr,
    input  logic [W-1:0]  dsk_wdata,
    input  logic          dsk_rd,
    output logic [W-1:0]  dsk_rdata,
    output logic          rqm,
    output logic          dio,
    output logic          drq,
    output logic          overrun,
    output logic          underrun,
    output logic          xfer_err,
    output logic          crc_append
);
    xfer_dir_e     dir;
    logic          exec_q;
    logic          exec_start;
    logic          flush;
    logic          fifo_mode;
    logic [CW-1:0] cap;
    logic [TW-1:0] thr_sel;
    logic          push;
    logic          pop;
    logic [W-1:0]  wdata;
    logic [W-1:0]  head;
    logic [CW-1:0] level;
    logic          full;
    logic          empty;
    logic          ovr_q;
    logic          unr;
    logic          req_en;
    logic          pad_active;

    // Mode, capacity and strobe steering.
    always_comb begin
        dir        = xfer_dir_e'(dir_to_host);
        exec_start = exec_active & ~exec_q;
        flush      = exec_start | cmd_start;
        fifo_mode  = cfg_fifo_en & exec_active;
        cap        = fifo_mode ? CW'(DEPTH) : CW'(1);
        thr_sel    = fifo_mode ? cfg_thresh : TW'(1);
        push       = (dir == XFER_TO_HOST) ? dsk_wr : (host_wr & ~unr);
        pop        = (dir == XFER_TO_HOST) ? host_rd : (dsk_rd & ~unr);
        wdata      = (dir == XFER_TO_HOST) ? dsk_wdata : host_wdata;
        req_en     = cfg_dma_en & exec_active & ~unr;
        pad_active = exec_active & (dir == XFER_TO_DISK) & ~exec_start;
    end

    // Execution entry edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) exec_q <= 1'b0;
        else        exec_q <= exec_active;
    end

    // Sticky overrun: disk byte arriving with no room during execution.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_start)
            ovr_q <= 1'b0;
        else if (exec_active && (dir == XFER_TO_HOST) && dsk_wr && full && !flush)
            ovr_q <= 1'b1;
    end

    disk_fifo_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .pop   (pop),
        .wdata (wdata),
        .cap   (cap),
        .head  (head),
        .level (level),
        .full  (full),
        .empty (empty)
    );

    disk_fifo_req #(.DEPTH(DEPTH)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .to_host (dir_to_host),
        .en      (req_en),
        .level   (level),
        .cap     (cap),
        .thr     (thr_sel),
        .drq     (drq)
    );

    disk_fifo_pad #(.LW(LW)) u_pad (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (cmd_start),
        .sec_clr   (exec_start),
        .active    (pad_active),
        .take      (dsk_rd),
        .empty     (empty),
        .sec_len   (sector_len),
        .underrun  (unr),
        .crc_pulse (crc_append)
    );

    // Host-visible data and status.
    always_comb begin
        host_rdata = (dir == XFER_TO_HOST) ? head : '0;
        dsk_rdata  = ((dir == XFER_TO_DISK) && !unr) ? head : '0;
        rqm        = (dir == XFER_TO_HOST) ? ~empty : (~full & ~unr);
        dio        = dir_to_host;
        overrun    = ovr_q;
        underrun   = unr;
        xfer_err   = ovr_q | unr;
    end
endmodule

// File: rtl/disk_data_fifo_chk.sv
// Module: property checker for disk_data_fifo, attached by bind.
// Assumes: connected to the top's ports and its internal level count.
module disk_data_fifo_chk #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_start,
    input logic          exec_active,
    input logic          dir_to_host,
    input logic          cfg_dma_en,
    input logic          dsk_wr,
    input logic          rqm,
    input logic          drq,
    input logic          overrun,
    input logic          underrun,
    input logic          crc_append,
    input logic [CW-1:0] level
);
    p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
    p_drq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drq |-> (cfg_dma_en && exec_active));
    p_drq_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drq && dir_to_host) |-> rqm);
    p_ovr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !cmd_start) |=> overrun);
    p_ovr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(dsk_wr));
    p_flags_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (!overrun && !underrun));
    p_unr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !cmd_start) |=> underrun);
    p_crc_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        crc_append |=> !crc_append);
    p_crc_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        crc_append |-> underrun);
endmodule

bind disk_data_fifo disk_data_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .exec_active (exec_active),
    .dir_to_host (dir_to_host),
    .cfg_dma_en  (cfg_dma_en),
    .dsk_wr      (dsk_wr),
    .rqm         (rqm),
    .drq         (drq),
    .overrun     (overrun),
    .underrun    (underrun),
    .crc_append  (crc_append),
    .level       (level)
);

// File: tb/disk_data_fifo_tb_top.sv
// Bench: scoreboard for disk_data_fifo. Driver tasks queue expected bytes.
// A negedge monitor compares each accepted pop against the queue.
module disk_data_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fifo_en = 1'b0;
    logic [3:0]  cfg_thresh = 4'd0;
    logic        cfg_dma_en = 1'b0;
    logic        cmd_start = 1'b0;
    logic        exec_active = 1'b0;
    logic        dir_to_host = 1'b0;
    logic [15:0] sector_len = 16'd4;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic        dsk_wr = 1'b0;
    logic [7:0]  dsk_wdata = 8'h00;
    logic        dsk_rd = 1'b0;
    logic [7:0]  dsk_rdata;
    logic        rqm, dio, drq, overrun, underrun, xfer_err, crc_append;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          mon_en = 1'b1;
    bit          done = 1'b0;
    logic [7:0]  exp_q [$];

    always #5 clk = ~clk;

    disk_data_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_thresh(cfg_thresh),
        .cfg_dma_en(cfg_dma_en), .cmd_start(cmd_start), .exec_active(exec_active),
        .dir_to_host(dir_to_host), .sector_len(sector_len), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .dsk_wr(dsk_wr), .dsk_wdata(dsk_wdata), .dsk_rd(dsk_rd), .dsk_rdata(dsk_rdata),
        .rqm(rqm), .dio(dio), .drq(drq), .overrun(overrun), .underrun(underrun),
        .xfer_err(xfer_err), .crc_append(crc_append)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic hw(input logic [7:0] b, input bit keep);
        host_wr = 1'b1; host_wdata = b;
        if (keep) exp_q.push_back(b);
        tick();
        host_wr = 1'b0;
    endtask

    task automatic dw(input logic [7:0] b, input bit keep);
        dsk_wr = 1'b1; dsk_wdata = b;
        if (keep) exp_q.push_back(b);
        tick();
        dsk_wr = 1'b0;
    endtask

    task automatic hr;
        host_rd = 1'b1;
        tick();
        host_rd = 1'b0;
    endtask

    task automatic dr;
        dsk_rd = 1'b1;
        tick();
        dsk_rd = 1'b0;
    endtask

    // Monitor: compare every pop against the scoreboard (R6 ordering).
    always @(negedge clk) begin
        if (mon_en && rst_n && ((dir_to_host && host_rd) || (!dir_to_host && dsk_rd))) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R6: actual pop expected none");
            end else begin
                logic [7:0] e;
                logic [7:0] a;
                e = exp_q.pop_front();
                a = dir_to_host ? host_rdata : dsk_rdata;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL R6: actual %0h expected %0h", a, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 rqm", rqm, 1); chk("R1 drq", drq, 0);
        chk("R1 overrun", overrun, 0); chk("R1 underrun", underrun, 0);
        chk("R1 crc_append", crc_append, 0); chk("R13 dio", dio, 0);

        // R3 command phase: one byte even with full depth enabled
        cfg_fifo_en = 1'b1;
        hw(8'hA1, 1);
        chk("R3 rqm after one byte", rqm, 0);
        hw(8'hA2, 0);
        dr();
        chk("R13 rqm after drain", rqm, 1);

        // R4 flush at execution entry
        dir_to_host = 1'b1;
        chk("R13 dio to host", dio, 1);
        dw(8'hB1, 0);
        chk("R13 rqm with byte", rqm, 1);
        cfg_dma_en = 1'b1; cfg_thresh = 4'd8;
        exec_active = 1'b1;
        tick();
        chk("R4 empty after exec entry", rqm, 0);

        // R5 to-host threshold and hysteresis
        for (int i = 0; i < 7; i++) dw(8'h10 + 8'(i), 1);
        chk("R5 drq below threshold", drq, 0);
        dw(8'h17, 1);
        chk("R5 drq at threshold", drq, 1);
        for (int i = 0; i < 7; i++) hr();
        chk("R5 drq held with one byte", drq, 1);
        hr();
        chk("R5 drq cleared at empty", drq, 0);

        // R6 full depth and R9 overrun
        for (int i = 0; i < 16; i++) dw(8'h40 + 8'(i), 1);
        chk("R6 rqm at full", rqm, 1);
        dw(8'hEE, 0);
        chk("R9 overrun set", overrun, 1);
        chk("R9 xfer_err set", xfer_err, 1);
        for (int i = 0; i < 16; i++) hr();
        chk("R9 drained", rqm, 0);
        chk("R9 overrun sticky", overrun, 1);

        // R8 DMA gating
        cfg_dma_en = 1'b0;
        for (int i = 0; i < 8; i++) dw(8'h60 + 8'(i), 1);
        chk("R8 drq off without dma", drq, 0);
        cfg_dma_en = 1'b1;
        #1;
        chk("R8 drq with dma", drq, 1);
        for (int i = 0; i < 8; i++) hr();

        // R10 clear on command start
        cmd_start = 1'b1; tick(); cmd_start = 1'b0;
        chk("R10 overrun cleared", overrun, 0);
        chk("R10 xfer_err cleared", xfer_err, 0);

        // R2 bypass during execution
        cfg_fifo_en = 1'b0; dir_to_host = 1'b0;
        #1;
        chk("R2 drq free one slot", drq, 1);
        hw(8'hC1, 1);
        chk("R2 rqm after one byte", rqm, 0);
        chk("R2 drq full", drq, 0);
        dr();
        chk("R2 drq after drain", drq, 1);

        // R7 to-disk threshold and hysteresis
        cfg_fifo_en = 1'b1; cfg_thresh = 4'd2;
        #1;
        chk("R7 drq empty", drq, 1);
        for (int i = 0; i < 16; i++) hw(8'h80 + 8'(i), 1);
        chk("R7 drq at full", drq, 0);
        chk("R13 rqm at full", rqm, 0);
        dr();
        chk("R7 drq one free", drq, 0);
        dr();
        chk("R7 drq two free", drq, 1);
        for (int i = 0; i < 14; i++) dr();

        // R11/R12 underrun, padding and CRC request
        cmd_start = 1'b1; tick(); cmd_start = 1'b0;
        hw(8'hD1, 1); hw(8'hD2, 1);
        dr(); dr();
        mon_en = 1'b0;
        dsk_rd = 1'b1;
        #1;
        chk("R11 zero on underrun", dsk_rdata, 8'h00);
        tick();
        dsk_rd = 1'b0;
        chk("R11 underrun set", underrun, 1);
        chk("R13 rqm low after underrun", rqm, 0);
        chk("R12 no crc yet", crc_append, 0);
        hw(8'hE1, 0);
        chk("R11 host write ignored", dsk_rdata, 8'h00);
        chk("R11 rqm stays low", rqm, 0);
        dr();
        chk("R12 crc pulse", crc_append, 1);
        tick();
        chk("R12 crc single", crc_append, 0);
        chk("R11 underrun sticky", underrun, 1);

        chk("R6 scoreboard empty", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule